// File: doc/BRIEF.md
# Shared Right-Shifter Bit-Manipulation Unit

This block is a 32-bit shift and bit-manipulation datapath that has only one shifter, and that shifter only shifts right. A left shift mirrors the operand's bit order, shifts it right and mirrors the result back. A fill bit placed above the operand selects between zero fill, sign fill and ones fill. For the single-bit set, clear and invert operations a multiplexer feeds the constant one into the shifter in place of operand a, so the same hardware builds the one-hot mask.

The same bit-mirror network and a byte-lane network also give the whole-word bit reversal, the byte-order swap and the per-byte OR-combine. All of the datapath is combinational. The result is captured in one output register, so every operation gives its result one clock after it is presented.

Top module: `bshift_alu`

## Requirements
- R1: Opcode 0 (shift left) returns a shifted left by b[4:0], with zeros filling the vacated low bits.
- R2: Opcode 1 (logical shift right) returns a shifted right by b[4:0], with zeros filling the vacated high bits.
- R3: Opcode 2 (arithmetic shift right) returns a shifted right by b[4:0], with copies of a[31] filling the vacated high bits.
- R4: Opcode 3 (ones-fill shift left) and opcode 4 (ones-fill shift right) behave like opcodes 0 and 1, except that the vacated positions are filled with 1s.
- R5: Only b[4:0] sets the shift amount or bit index. Bits b[31:5] have no effect on the result.
- R6: The mask is 1 << b[4:0]. Opcode 5 returns a OR mask, opcode 6 returns a AND NOT mask, and opcode 7 returns a XOR mask.
- R7: Opcode 8 (bit extract) returns bit b[4:0] of a in result bit 0, and every other result bit is 0.
- R8: Opcode 9 returns a with its bit order reversed, so that result bit i equals a[31-i].
- R9: Opcode 10 returns a with its byte order reversed, so that result byte k equals byte 3-k of a.
- R10: Opcode 11 sets each result byte to 0xFF when the matching byte of a has any bit set, and to 0x00 when it does not.
- R11: Opcodes 12 to 15 return 0.
- R12: The result is registered. The value for the inputs present at a rising clock edge appears just after that edge, and the result is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset that clears the output register |
| op | input | 4 | Operation select, encoded as in the requirements |
| a | input | 32 | Data operand |
| b | input | 32 | Shift amount or bit index in b[4:0] |
| result | output | 32 | Registered result |

## Verification
The only stored state is the output register. A fault in the mirror controls, the fill selection or the constant-one multiplexer therefore shows at the ports one clock after the bad operation is presented. It appears as a mirrored word, wrong fill bits, or a mask at the wrong position. The vectors are chosen with asymmetric operands and with shift amounts at the extremes (0, 4 and 31), so that a mirror left on, or left off, changes the visible value. Vectors with set upper bits in b expose a shift amount that is decoded too wide.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [3:0] {
      OP_SHL   = 4'd0,
      OP_SHR   = 4'd1,
      OP_ASR   = 4'd2,
      OP_ONESL = 4'd3,
      OP_ONESR = 4'd4,
      OP_BSET  = 4'd5,
      OP_BCLR  = 4'd6,
      OP_BFLIP = 4'd7,
      OP_BGET  = 4'd8,
      OP_BREV  = 4'd9,
      OP_BSWAP = 4'd10,
      OP_BORC  = 4'd11
   } op_e;

   typedef enum logic [1:0] {
      FILL_ZERO = 2'd0,
      FILL_SIGN = 2'd1,
      FILL_ONE  = 2'd2
   } fill_e;

endpackage

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   input  logic         en,
   output logic [W-1:0] dout
);
   logic [W-1:0] flipped;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign flipped[i] = din[W-1-i];
   end

   assign dout = en ? flipped : din;
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
   parameter int W = 32,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic          fill,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);
   logic signed [W:0] ext;
   logic signed [W:0] shifted;
   logic              unused_top;

   assign ext        = {fill, din};
   assign shifted    = ext >>> amt;
   assign dout       = shifted[W-1:0];
   assign unused_top = shifted[W];
endmodule

// File: rtl/bshift_lanes.sv
module bshift_lanes #(
   parameter int W = 32,
   localparam int NB = W / 8
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] swapped,
   output logic [W-1:0] orcomb
);
   for (genvar k = 0; k < NB; k++) begin : g_lane
      assign swapped[8*k +: 8] = din[8*(NB-1-k) +: 8];
      assign orcomb[8*k +: 8]  = {8{|din[8*k +: 8]}};
   end
endmodule

// File: rtl/bshift_alu.sv
module bshift_alu #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] result
);
   import bshift_pkg::*;

   localparam int SW = $clog2(W);

   if (W < 8 || (W % 8) != 0 || (1 << SW) != W) begin : g_bad_width
      $error("bshift_alu: W must be a power of two and at least 8");
   end

   op_e           opc;
   fill_e         fill_sel;
   logic          mir_in, mir_out, use_one, amt_zero;
   logic [W-1:0]  src, pre, sh, post, mask, swapped, orcomb;
   logic [SW-1:0] amt;
   logic          fill;
   logic [W-1:0]  nxt;
   logic          unused_b;

   assign opc      = op_e'(op);
   assign unused_b = ^b[W-1:SW];

   // decode: mirror controls, fill source, constant-one select
   always_comb begin
      mir_in   = 1'b0;
      mir_out  = 1'b0;
      use_one  = 1'b0;
      amt_zero = 1'b0;
      fill_sel = FILL_ZERO;
      unique case (opc)
         OP_SHL:   begin mir_in = 1'b1; mir_out = 1'b1; end
         OP_ONESL: begin mir_in = 1'b1; mir_out = 1'b1; fill_sel = FILL_ONE; end
         OP_ONESR: fill_sel = FILL_ONE;
         OP_ASR:   fill_sel = FILL_SIGN;
         OP_BSET, OP_BCLR, OP_BFLIP:
                   begin mir_in = 1'b1; mir_out = 1'b1; use_one = 1'b1; end
         OP_BREV:  begin mir_out = 1'b1; amt_zero = 1'b1; end
         default:  ;
      endcase
   end

   always_comb begin
      unique case (fill_sel)
         FILL_SIGN: fill = a[W-1];
         FILL_ONE:  fill = 1'b1;
         default:   fill = 1'b0;
      endcase
   end

   assign src = use_one ? {{(W-1){1'b0}}, 1'b1} : a;
   assign amt = amt_zero ? '0 : b[SW-1:0];

   bshift_mirror #(.W(W)) u_mir_in (.din(src), .en(mir_in), .dout(pre));
   bshift_core   #(.W(W)) u_core   (.din(pre), .fill(fill), .amt(amt), .dout(sh));
   bshift_mirror #(.W(W)) u_mir_out(.din(sh), .en(mir_out), .dout(post));
   bshift_lanes  #(.W(W)) u_lanes  (.din(a), .swapped(swapped), .orcomb(orcomb));

   assign mask = post;

   always_comb begin
      nxt = '0;
      unique case (opc)
         OP_SHL, OP_SHR, OP_ASR, OP_ONESL, OP_ONESR, OP_BREV: nxt = post;
         OP_BSET:  nxt = a | mask;
         OP_BCLR:  nxt = a & ~mask;
         OP_BFLIP: nxt = a ^ mask;
         OP_BGET:  nxt = {{(W-1){1'b0}}, post[0]};
         OP_BSWAP: nxt = swapped;
         OP_BORC:  nxt = orcomb;
         default:  nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= nxt;
   end
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [3:0]   op,
   input logic [W-1:0] a,
   input logic [W-1:0] b,
   input logic [W-1:0] result
);
   localparam int SW = $clog2(W);

   // R1
   a_r1_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd0 |=> result == ($past(a) << $past(b[SW-1:0])));
   // R3
   a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd2 |=> result[W-1] == $past(a[W-1]));
   // R6
   a_r6_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd5 |=> ((result & $past(a)) == $past(a)) && ($countones(result ^ $past(a)) <= 1));
   // R7
   a_r7_extract_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd8 |=> result[W-1:1] == '0);
   // R8
   a_r8_reverse_weight: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd9 |=> $countones(result) == $countones($past(a)));
   // R9
   a_r9_swap_weight: assert property (@(posedge clk) disable iff (!rst_n)
      op == 4'd10 |=> $countones(result) == $countones($past(a)));
   // R11
   a_r11_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op >= 4'd12 |=> result == '0);
endmodule

bind bshift_alu bshift_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bshift_alu.sv
`timescale 1ns/1ps
module sim_bshift_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] a = '0, b = '0;
   logic [31:0] result;
   int          n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;

   bshift_alu u0 (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .result(result));

   localparam int NV = 21;
   // {op, a, b, expected}
   localparam logic [99:0] VEC [NV] = '{
      {4'd0,  32'h0000_0001, 32'h0000_0004, 32'h0000_0010},
      {4'd0,  32'h8000_0001, 32'h0000_001F, 32'h8000_0000},
      {4'd0,  32'h1234_5678, 32'h0000_0024, 32'h2345_6780},
      {4'd1,  32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
      {4'd1,  32'h1234_5678, 32'hFFFF_FFE4, 32'h0123_4567},
      {4'd2,  32'h8000_0000, 32'h0000_0004, 32'hF800_0000},
      {4'd2,  32'h4000_0000, 32'h0000_0004, 32'h0400_0000},
      {4'd3,  32'h0000_0000, 32'h0000_0004, 32'h0000_000F},
      {4'd4,  32'h0000_0000, 32'h0000_0008, 32'hFF00_0000},
      {4'd4,  32'h0000_0005, 32'h0000_0000, 32'h0000_0005},
      {4'd5,  32'h0000_0000, 32'h0000_001F, 32'h8000_0000},
      {4'd6,  32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFE},
      {4'd7,  32'h0000_00F0, 32'h0000_0004, 32'h0000_00E0},
      {4'd8,  32'h0000_0100, 32'h0000_0008, 32'h0000_0001},
      {4'd8,  32'h0000_0100, 32'h0000_0029, 32'h0000_0000},
      {4'd9,  32'h0000_0001, 32'h0000_0000, 32'h8000_0000},
      {4'd9,  32'h1234_5678, 32'h0000_0007, 32'h1E6A_2C48},
      {4'd10, 32'h1234_5678, 32'h0000_0000, 32'h7856_3412},
      {4'd11, 32'h0100_8000, 32'h0000_0000, 32'hFF00_FF00},
      {4'd12, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0000},
      {4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   function automatic string tag_of(input logic [3:0] o);
      case (o)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3, 4'd4: return "R4";
         4'd5, 4'd6, 4'd7: return "R6";
         4'd8: return "R7";
         4'd9: return "R8";
         4'd10: return "R9";
         4'd11: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: result=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      op = o; a = x; b = y;
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: result=%h expected=done", result);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      // R12: output held at zero in reset, even with a live operation present
      op = 4'd11; a = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      #1 check("R12", result, 32'h0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32]);
         check(tag_of(VEC[i][99:96]), result, VEC[i][31:0]);
      end

      // R5: upper bits of b ignored for set and extract
      apply(4'd5, 32'h0000_0000, 32'hFFFF_FFE3);
      check("R5", result, 32'h0000_0008);
      apply(4'd8, 32'h8000_0000, 32'h7FFF_FFFF);
      check("R5", result, 32'h0000_0001);

      // R12: result tracks the previous edge only, not the live inputs
      apply(4'd0, 32'h0000_0001, 32'h0000_0001);
      @(negedge clk);
      op = 4'd1; a = 32'h0000_0100; b = 32'h0000_0004;
      #2 check("R12", result, 32'h0000_0002);
      @(posedge clk); #1;
      check("R12", result, 32'h0000_0010);

      // R12: asynchronous reset clears the register
      @(negedge clk) rst_n = 1'b0;
      #2 check("R12", result, 32'h0);
      rst_n = 1'b1;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule